// File: doc/BRIEF.md
# Parallel IPv4 Header Anomaly Detector

This block screens IPv4 headers at line rate. Each clock it can take one 192-bit header window, that is the first twelve 16-bit halfwords of the header, together with the flag byte of the TCP segment that follows it. The block registers the window once. Three independent checkers then look at the same registered word side by side.

The first checker verifies the header checksum. The second checks that the fragmentation fields are sane, which catches oversize-reassembly and overlapping-fragment tricks. The third rejects TCP segments whose control flags are all set or all clear, a pattern that scanners use to fingerprint hosts.

Each checker yields a single alarm bit. The three bits are packed into a 32-bit status word, which leaves the block on a registered output with a valid strobe two cycles after the header went in. There is no stall path. Software or a downstream classifier consumes the status word directly.

Top module: `ipv4_anomaly_scan`

## Requirements
- R1: A header is accepted on every cycle in which `hdr_valid_i` is high, with no stall path. `alarm_valid_o` equals `hdr_valid_i` delayed by exactly two clock cycles, and the status word goes with it.
- R2: Halfword k of the window is `hdr_word_i[191-16k -: 16]`. IHL is bits [187:184]. The checksum alarm (status bit 0) is set when the ones-complement sum, with end-around carry, of the first IHL×2 halfwords is not 0xFFFF. Halfwords beyond IHL×2 do not affect the result.
- R3: An IHL below 5 or above 6 sets the checksum alarm, whatever the checksum field holds.
- R4: Total length is bits [175:160]. The fragment field is bits [143:128], laid out as reserved bit 143, DF bit 142, MF bit 141 and a 13-bit offset in [140:128]. The fragment alarm (status bit 1) is set when offset×8 + total length − IHL×4 exceeds 65535.
- R5: The fragment alarm is set when MF is 1 and the payload length (total length − IHL×4) is not a multiple of 8.
- R6: The fragment alarm is set when DF is 1 while MF is 1 or the offset is nonzero, and also when the reserved bit is 1.
- R7: The protocol is bits [119:112]. The TCP flag byte uses FIN bit 0, SYN bit 1, RST bit 2, PSH bit 3, ACK bit 4 and URG bit 5. When the protocol is 6, the flag alarm (status bit 2) is set if all six of these flags are 1 or all six are 0. Bits 7:6 are ignored.
- R8: For any protocol other than 6, the flag alarm is 0.
- R9: Status bits 31:3 are always 0.
- R10: A synchronous active-high reset clears `alarm_valid_o` and the status word on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid_i | input | 1 | Header window valid |
| hdr_word_i | input | 192 | First 24 bytes of the IPv4 header, byte 0 at the top |
| tcp_flags_i | input | 8 | TCP flag byte that belongs to this header |
| alarm_valid_o | output | 1 | Status word valid, two cycles after input |
| alarm_word_o | output | 32 | Packed alarm bits: 0 checksum, 1 fragment, 2 TCP flags |

## Verification
The assertions assume that `hdr_valid_i` and the header fields are known (not X) on every clock edge after reset. They also assume that reset, once released, stays low for at least two cycles before a latency check applies. The bench drives every input from its negative-edge tasks, with fully defined values. It keeps reset low across the whole table walk, and it pulses reset only in the directed test that checks clearing. Its headers always carry version 4, and it builds the checksums itself.

// File: rtl/ipv4_scan_pkg.sv
package ipv4_scan_pkg;
  localparam int HDR_W     = 192;
  localparam int HW_W      = 16;
  localparam int N_HW      = HDR_W / HW_W;
  localparam int STATUS_W  = 32;
  localparam int TFLAG_W   = 8;
  localparam int N_CHECKS  = 3;
  // status bit positions
  localparam int ST_CSUM   = 0;
  localparam int ST_FRAG   = 1;
  localparam int ST_FLAG   = 2;
  // field positions inside the header window
  localparam int IHL_MSB   = HDR_W - 5;
  localparam int TLEN_MSB  = HDR_W - 17;
  localparam int FRAG_MSB  = HDR_W - 49;
  localparam int PROTO_MSB = HDR_W - 73;
  localparam logic [7:0] PROTO_TCP = 8'd6;
endpackage

// File: rtl/ipv4_csum_check.sv
module ipv4_csum_check
  import ipv4_scan_pkg::*;
#(
  parameter int WIN_W   = HDR_W,
  parameter int MIN_IHL = 5
) (
  input  logic [WIN_W-1:0] hdr,
  output logic             alarm
);
  localparam int NW    = WIN_W / HW_W;
  localparam int MAX_IHL = WIN_W / 32;
  localparam int SUM_W = HW_W + $clog2(NW);

  logic [3:0]      ihl;
  logic [4:0]      n_used;
  logic [HW_W-1:0] words [NW];
  logic [NW-1:0]   use_w;
  logic [SUM_W-1:0] sum;
  logic [HW_W:0]   fold1;
  logic [HW_W-1:0] fold2;
  logic            ihl_ok;

  assign ihl    = hdr[IHL_MSB -: 4];
  assign n_used = {ihl, 1'b0};

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign words[g] = hdr[WIN_W-1-HW_W*g -: HW_W];
    assign use_w[g] = 5'(g) < n_used;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NW; i++) begin
      if (use_w[i]) sum = sum + SUM_W'(words[i]);
    end
  end

  assign fold1  = (HW_W+1)'(sum[HW_W-1:0]) + (HW_W+1)'(sum[SUM_W-1:HW_W]);
  assign fold2  = fold1[HW_W-1:0] + HW_W'(fold1[HW_W]);
  assign ihl_ok = (ihl >= 4'(MIN_IHL)) && (ihl <= 4'(MAX_IHL));
  assign alarm  = !ihl_ok || (fold2 != '1);
endmodule

// File: rtl/ipv4_frag_check.sv
module ipv4_frag_check
  import ipv4_scan_pkg::*;
#(
  parameter int WIN_W = HDR_W
) (
  input  logic [WIN_W-1:0] hdr,
  output logic             alarm
);
  localparam int LEN_W = 16;
  localparam int OFF_W = 13;
  localparam int EXT_W = LEN_W + 1;

  logic [3:0]       ihl;
  logic [LEN_W-1:0] tot_len;
  logic             rsv, dont_frag, more_frag;
  logic [OFF_W-1:0] offset;
  logic [5:0]       hdr_bytes;
  logic [EXT_W-1:0] frag_end, end_limit;
  logic [2:0]       pay_mod8;
  logic             too_long, misaligned, df_conflict;

  assign ihl       = hdr[IHL_MSB -: 4];
  assign tot_len   = hdr[TLEN_MSB -: LEN_W];
  assign rsv       = hdr[FRAG_MSB];
  assign dont_frag = hdr[FRAG_MSB-1];
  assign more_frag = hdr[FRAG_MSB-2];
  assign offset    = hdr[FRAG_MSB-3 -: OFF_W];
  assign hdr_bytes = {ihl, 2'b00};

  // offset*8 + len - hlen > 65535  <=>  offset*8 + len > hlen + 65535
  assign frag_end  = EXT_W'({offset, 3'b000}) + EXT_W'(tot_len);
  assign end_limit = EXT_W'(hdr_bytes) + EXT_W'(17'h0FFFF);
  assign too_long  = frag_end > end_limit;

  assign pay_mod8    = tot_len[2:0] - hdr_bytes[2:0];
  assign misaligned  = more_frag && (pay_mod8 != 3'd0);
  assign df_conflict = dont_frag && (more_frag || (offset != '0));

  assign alarm = too_long || misaligned || df_conflict || rsv;
endmodule

// File: rtl/ipv4_flag_check.sv
module ipv4_flag_check
  import ipv4_scan_pkg::*;
#(
  parameter int WIN_W     = HDR_W,
  parameter int CLASSIC_W = 6
) (
  input  logic [WIN_W-1:0]   hdr,
  input  logic [TFLAG_W-1:0] tflags,
  output logic               alarm
);
  logic [CLASSIC_W-1:0] classic;
  logic                 is_tcp;

  assign classic = tflags[CLASSIC_W-1:0];
  assign is_tcp  = hdr[PROTO_MSB -: 8] == PROTO_TCP;
  assign alarm   = is_tcp && ((classic == '1) || (classic == '0));
endmodule

// File: rtl/ipv4_anomaly_scan.sv
module ipv4_anomaly_scan
  import ipv4_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_valid_i,
  input  logic [HDR_W-1:0]    hdr_word_i,
  input  logic [TFLAG_W-1:0]  tcp_flags_i,
  output logic                alarm_valid_o,
  output logic [STATUS_W-1:0] alarm_word_o
);
  logic               s1_valid;
  logic [HDR_W-1:0]   s1_hdr;
  logic [TFLAG_W-1:0] s1_tflags;
  logic [N_CHECKS-1:0] hits;
  logic [STATUS_W-1:0] packed_word;

  // stage 1: shared input register
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= hdr_valid_i;
    s1_hdr    <= hdr_word_i;
    s1_tflags <= tcp_flags_i;
  end

  ipv4_csum_check #(.WIN_W(HDR_W)) u_csum (
    .hdr(s1_hdr), .alarm(hits[ST_CSUM]));

  ipv4_frag_check #(.WIN_W(HDR_W)) u_frag (
    .hdr(s1_hdr), .alarm(hits[ST_FRAG]));

  ipv4_flag_check #(.WIN_W(HDR_W)) u_flag (
    .hdr(s1_hdr), .tflags(s1_tflags), .alarm(hits[ST_FLAG]));

  assign packed_word = {{(STATUS_W-N_CHECKS){1'b0}}, hits};

  // stage 2: registered status
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_valid_o <= 1'b0;
      alarm_word_o  <= '0;
    end else begin
      alarm_valid_o <= s1_valid;
      if (s1_valid) alarm_word_o <= packed_word;
    end
  end
endmodule

// File: rtl/ipv4_anomaly_scan_chk.sv
module ipv4_anomaly_scan_chk
  import ipv4_scan_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                hdr_valid_i,
  input logic [HDR_W-1:0]    hdr_word_i,
  input logic                alarm_valid_o,
  input logic [STATUS_W-1:0] alarm_word_o
);
  logic [1:0] since_rst;
  logic [3:0] in_ihl;
  logic [7:0] in_proto;

  assign in_ihl   = hdr_word_i[IHL_MSB -: 4];
  assign in_proto = hdr_word_i[PROTO_MSB -: 8];

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (alarm_valid_o == $past(hdr_valid_i, 2)));

  assert_ihl_range_R3: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid_i && (in_ihl < 4'd5 || in_ihl > 4'd6)) |=> ##1 alarm_word_o[ST_CSUM]);

  assert_reserved_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid_i && hdr_word_i[FRAG_MSB]) |=> ##1 alarm_word_o[ST_FRAG]);

  assert_non_tcp_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid_i && in_proto != PROTO_TCP) |=> ##1 !alarm_word_o[ST_FLAG]);

  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (rst)
    alarm_word_o[STATUS_W-1:N_CHECKS] == '0);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!alarm_valid_o && alarm_word_o == '0));
endmodule

bind ipv4_anomaly_scan ipv4_anomaly_scan_chk i_chk (
  .clk(clk), .rst(rst), .hdr_valid_i(hdr_valid_i), .hdr_word_i(hdr_word_i),
  .alarm_valid_o(alarm_valid_o), .alarm_word_o(alarm_word_o));

// File: tb/test_ipv4_anomaly_scan.sv
module test_ipv4_anomaly_scan;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 21;

  typedef struct packed {
    logic [3:0]  ihl;
    logic [15:0] tl;
    logic        rsv, df, mf;
    logic [12:0] off;
    logic [7:0]  proto;
    logic [7:0]  tfl;
    logic        bad;
    logic [2:0]  exp;  // {flag, frag, csum}
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h10, 1'b0, 3'b000}, // clean TCP ACK
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h10, 1'b1, 3'b001}, // R2 bad checksum
    '{4'd6, 16'd48,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h10, 1'b0, 3'b000}, // R2 IHL 6
    '{4'd4, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd17, 8'h00, 1'b0, 3'b001}, // R3 IHL 4
    '{4'd7, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd17, 8'h00, 1'b0, 3'b001}, // R3 IHL 7
    '{4'd5, 16'd1500, 1'b0,1'b0,1'b0, 13'd8185, 8'd17, 8'h00, 1'b0, 3'b010}, // R4 oversize
    '{4'd5, 16'd1555, 1'b0,1'b0,1'b0, 13'd8000, 8'd17, 8'h00, 1'b0, 3'b000}, // R4 end = 65535
    '{4'd5, 16'd1556, 1'b0,1'b0,1'b0, 13'd8000, 8'd17, 8'h00, 1'b0, 3'b010}, // R4 end = 65536
    '{4'd5, 16'd41,   1'b0,1'b0,1'b1, 13'd0,    8'd17, 8'h00, 1'b0, 3'b010}, // R5 MF, payload 21
    '{4'd5, 16'd44,   1'b0,1'b0,1'b1, 13'd0,    8'd17, 8'h00, 1'b0, 3'b000}, // R5 MF, payload 24
    '{4'd5, 16'd44,   1'b0,1'b1,1'b1, 13'd0,    8'd17, 8'h00, 1'b0, 3'b010}, // R6 DF+MF
    '{4'd5, 16'd40,   1'b0,1'b1,1'b0, 13'd1,    8'd17, 8'h00, 1'b0, 3'b010}, // R6 DF+offset
    '{4'd5, 16'd40,   1'b0,1'b1,1'b0, 13'd0,    8'd17, 8'h00, 1'b0, 3'b000}, // R6 DF alone
    '{4'd5, 16'd40,   1'b1,1'b0,1'b0, 13'd0,    8'd17, 8'h00, 1'b0, 3'b010}, // R6 reserved
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h3F, 1'b0, 3'b100}, // R7 all set
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h00, 1'b0, 3'b100}, // R7 none set
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'hC0, 1'b0, 3'b100}, // R7 only top bits
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'hFF, 1'b0, 3'b100}, // R7 byte FF
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd17, 8'h00, 1'b0, 3'b000}, // R8 UDP, flags 0
    '{4'd5, 16'd40,   1'b1,1'b0,1'b0, 13'd0,    8'd6,  8'h3F, 1'b1, 3'b111}, // all alarms
    '{4'd5, 16'd40,   1'b0,1'b0,1'b0, 13'd0,    8'd6,  8'h02, 1'b0, 3'b000}  // R7 SYN only
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         hdr_valid_i;
  logic [191:0] hdr_word_i;
  logic [7:0]   tcp_flags_i;
  logic         alarm_valid_o;
  logic [31:0]  alarm_word_o;
  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipv4_anomaly_scan i_ipv4_anomaly_scan (
    .clk(clk), .rst(rst), .hdr_valid_i(hdr_valid_i), .hdr_word_i(hdr_word_i),
    .tcp_flags_i(tcp_flags_i), .alarm_valid_o(alarm_valid_o), .alarm_word_o(alarm_word_o));

  function automatic logic [191:0] make_hdr(vec_t v, int seed);
    logic [191:0] h;
    logic [31:0]  acc;
    logic [15:0]  ck;
    int           n;
    h = '0;
    h[191:188] = 4'd4;
    h[187:184] = v.ihl;
    h[175:160] = v.tl;
    h[159:144] = 16'(seed * 37 + 1);
    h[143:128] = {v.rsv, v.df, v.mf, v.off};
    h[127:120] = 8'd64;
    h[119:112] = v.proto;
    h[95:64]   = 32'hC0A8_0001 + 32'(seed);
    h[63:32]   = 32'h0A00_0002;
    h[31:0]    = 32'hDEAD_BEEF ^ 32'(seed);
    n = int'(v.ihl) * 2;
    if (n > 12) n = 12;
    acc = '0;
    for (int i = 0; i < n; i++) acc = acc + 32'(h[191-16*i -: 16]);
    while (acc[31:16] != 16'd0) acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    ck = ~acc[15:0];
    if (v.bad) ck = ck ^ 16'h0001;
    h[111:96] = ck;
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; hdr_valid_i = 1'b0; hdr_word_i = '0; tcp_flags_i = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 32'(alarm_valid_o), 32'd0);
    chk("R10 reset word", alarm_word_o, 32'd0);
    rst = 1'b0;

    // table walk, back to back, one header per cycle (R1)
    for (int k = 0; k < N_VEC + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R1 valid after two cycles", 32'(alarm_valid_o), 32'd1);
        chk("R2 R3 checksum bit", 32'(alarm_word_o[0]), 32'(VECS[k-2].exp[0]));
        chk("R4 R5 R6 fragment bit", 32'(alarm_word_o[1]), 32'(VECS[k-2].exp[1]));
        chk("R7 R8 flag bit", 32'(alarm_word_o[2]), 32'(VECS[k-2].exp[2]));
        chk("R9 spare bits", {3'b000, alarm_word_o[31:3]}, 32'd0);
      end
      if (k < N_VEC) begin
        hdr_valid_i = 1'b1;
        hdr_word_i  = make_hdr(VECS[k], k);
        tcp_flags_i = VECS[k].tfl;
      end else begin
        hdr_valid_i = 1'b0;
      end
    end

    // R1: a bubble in the input gives a bubble two cycles later
    hdr_valid_i = 1'b1; hdr_word_i = make_hdr(VECS[0], 3); tcp_flags_i = 8'h10;
    @(negedge clk);
    hdr_valid_i = 1'b0;
    @(negedge clk);
    chk("R1 valid for header before bubble", 32'(alarm_valid_o), 32'd1);
    @(negedge clk);
    chk("R1 bubble propagates", 32'(alarm_valid_o), 32'd0);

    // R10: reset in flight clears the output
    hdr_valid_i = 1'b1; hdr_word_i = make_hdr(VECS[19], 5); tcp_flags_i = 8'h3F;
    @(negedge clk);
    hdr_valid_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R10 valid cleared by reset", 32'(alarm_valid_o), 32'd0);
    chk("R10 word cleared by reset", alarm_word_o, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 no output after reset", 32'(alarm_valid_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule